// File: doc/BRIEF.md
# Grouped reply interrupt coalescer

This block sits between the completion path of a storage controller and its interrupt generator. Every completion (reply) arrives as one transfer on a valid/ready stream, carrying the index of the reply queue it belongs to. The block gathers the replies into a pending set and raises one interrupt pulse for the whole set. With the pulse it reports the queue the interrupt is attributed to and the number of replies it covers.

Queues form groups of eight consecutive indices, and a pending set never spans two groups. A set is flushed when it reaches the programmed depth. It is also flushed when its age, counted in ticks of an external 500 ns strobe, goes past the programmed timeout. A reply to another group, or to a queue whose coalescing flag is cleared, flushes it too. A queue with its flag cleared raises one interrupt per reply.

The reply stream follows the usual valid/ready rules. A transfer happens in a cycle where `rep_valid` and `rep_ready` are both high. Once the source raises `rep_valid`, it holds `rep_valid` and `rep_queue` steady until that transfer. The block lowers `rep_ready` only for a cycle in which it must flush the existing set before it can take the offered reply. The interrupt output is a plain one-cycle pulse with no back-pressure.

Top module: `reply_coalescer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `irq_valid` is 0, `rep_ready` is 1, and no replies are pending.
- R2: The group of a queue is its index divided by 8. Replies to queues of one group, all with coalescing enabled, add to the same pending set, and `irq_queue` of the flush is the queue of the last reply added.
- R3: When an accepted reply brings the pending count to the programmed depth or more, the set is flushed with that count. A depth of 0 acts as a depth of 1.
- R4: The age counter is set to 0 on the edge that accepts the first reply of an empty set. It then grows by one on each later edge where `tick` is high, and saturates at 16 bits. Once it exceeds `cfg_timeout`, the set is flushed in that cycle.
- R5: A reply offered to a different group while a set is pending sees `rep_ready` low. The old set is flushed in that cycle. The reply is taken in the next cycle as the first reply of a new set, which restarts the age counter.
- R6: A reply to a queue whose bit in `cfg_coal_en` is 0 first forces out any pending set, with `rep_ready` low for one cycle. Once accepted, it gives an interrupt of count 1 attributed to that queue.
- R7: A flush decided on a clock edge shows up after that edge as a one-cycle `irq_valid` pulse, with `irq_queue` and `irq_count` valid alongside it. `irq_count` is never 0.
- R8: `rep_ready` is low only while a set is pending and a timeout or conflict flush is due.
- R9: With depth 4 and timeout 0x20, replies to groups 4,4,6,6 give two interrupts. Replies to groups 4,5,6,7 give four. Five replies to group 4 and then one to group 5 give three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe every 500 ns |
| cfg_depth | input | 8 | Replies per interrupt (0 acts as 1) |
| cfg_timeout | input | 16 | Age limit in ticks |
| cfg_coal_en | input | 128 | Per-queue coalescing enable, bit n for queue n |
| rep_valid | input | 1 | Reply offered |
| rep_ready | output | 1 | Reply can be taken this cycle |
| rep_queue | input | 7 | Reply queue index |
| irq_valid | output | 1 | Interrupt pulse |
| irq_queue | output | 7 | Queue the interrupt is attributed to |
| irq_count | output | 8 | Replies covered by the interrupt |

## Verification
The properties assume three things about the inputs. `cfg_depth`, `cfg_timeout` and `cfg_coal_en` only change while no set is pending. A source holds `rep_queue` steady while `rep_ready` is low. `rep_valid` stays low during reset. The stimulus keeps to all three. It changes configuration only after draining every pending set, with a short timeout and a tick on every cycle. It holds each offered reply until the model sees it accepted, and it raises no request before reset is released.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_START = 2'd1,
    OP_ADD   = 2'd2,
    OP_CLEAR = 2'd3
  } pend_op_e;

endpackage

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             active,
  input  logic [TMO_W-1:0] cfg_timeout,
  output logic             expired
);
  localparam logic [TMO_W-1:0] AGE_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0;
    end else if (restart) begin
      age <= '0;
    end else if (active && tick && age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end

  assign expired = active && (age > cfg_timeout);
endmodule

// File: rtl/coal_pending.sv
module coal_pending
  import coal_pkg::*;
#(
  parameter int QW    = 7,
  parameter int GSH   = 3,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pend_op_e          op,
  input  logic [QW-1:0]     q,
  output logic              pending,
  output logic [CNT_W-1:0]  cnt,
  output logic [QW-GSH-1:0] grp,
  output logic [QW-1:0]     last_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
      grp     <= '0;
      last_q  <= '0;
    end else begin
      unique case (op)
        OP_START: begin
          pending <= 1'b1;
          cnt     <= CNT_W'(1);
          grp     <= q[QW-1:GSH];
          last_q  <= q;
        end
        OP_ADD: begin
          cnt    <= cnt + 1'b1;
          last_q <= q;
        end
        OP_CLEAR: begin
          pending <= 1'b0;
          cnt     <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coal_decide.sv
module coal_decide
  import coal_pkg::*;
#(
  parameter int NQ    = 128,
  parameter int QW    = 7,
  parameter int GSH   = 3,
  parameter int CNT_W = 8
) (
  input  logic              pending,
  input  logic [CNT_W-1:0]  pend_cnt,
  input  logic [QW-GSH-1:0] pend_grp,
  input  logic [QW-1:0]     last_q,
  input  logic              tmo_expired,
  input  logic              rep_valid,
  input  logic [QW-1:0]     rep_queue,
  input  logic [NQ-1:0]     cfg_coal_en,
  input  logic [CNT_W-1:0]  cfg_depth,
  output logic              rep_ready,
  output pend_op_e          op,
  output logic              flush,
  output logic [CNT_W-1:0]  flush_cnt,
  output logic [QW-1:0]     flush_q
);
  logic             solo;
  logic             conflict;
  logic [CNT_W-1:0] depth_eff;
  logic [CNT_W-1:0] grown;

  assign solo      = !cfg_coal_en[rep_queue];
  assign conflict  = pending && rep_valid && ((rep_queue[QW-1:GSH] != pend_grp) || solo);
  assign depth_eff = (cfg_depth == '0) ? CNT_W'(1) : cfg_depth;
  assign grown     = pending ? pend_cnt + 1'b1 : CNT_W'(1);

  always_comb begin
    rep_ready = 1'b1;
    op        = OP_HOLD;
    flush     = 1'b0;
    flush_cnt = pend_cnt;
    flush_q   = last_q;
    if (tmo_expired || conflict) begin
      rep_ready = 1'b0;
      op        = OP_CLEAR;
      flush     = 1'b1;
    end else if (rep_valid) begin
      if (solo) begin
        flush     = 1'b1;
        flush_cnt = CNT_W'(1);
        flush_q   = rep_queue;
      end else if (grown >= depth_eff) begin
        op        = OP_CLEAR;
        flush     = 1'b1;
        flush_cnt = grown;
        flush_q   = rep_queue;
      end else begin
        op = pending ? OP_ADD : OP_START;
      end
    end
  end
endmodule

// File: rtl/reply_coalescer.sv
module reply_coalescer
  import coal_pkg::*;
#(
  parameter int NUM_QUEUES = 128,
  parameter int GROUP_SIZE = 8,
  parameter int CNT_W      = 8,
  parameter int TMO_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             cfg_depth,
  input  logic [TMO_W-1:0]             cfg_timeout,
  input  logic [NUM_QUEUES-1:0]        cfg_coal_en,
  input  logic                         rep_valid,
  output logic                         rep_ready,
  input  logic [$clog2(NUM_QUEUES)-1:0] rep_queue,
  output logic                         irq_valid,
  output logic [$clog2(NUM_QUEUES)-1:0] irq_queue,
  output logic [CNT_W-1:0]             irq_count
);
  localparam int QW  = $clog2(NUM_QUEUES);
  localparam int GSH = $clog2(GROUP_SIZE);
  localparam int GW  = QW - GSH;

  pend_op_e         op;
  logic             pending;
  logic [CNT_W-1:0] pend_cnt;
  logic [GW-1:0]    pend_grp;
  logic [QW-1:0]    last_q;
  logic             tmo_expired;
  logic             flush;
  logic [CNT_W-1:0] flush_cnt;
  logic [QW-1:0]    flush_q;

  coal_pending #(.QW(QW), .GSH(GSH), .CNT_W(CNT_W)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .q      (rep_queue),
    .pending(pending),
    .cnt    (pend_cnt),
    .grp    (pend_grp),
    .last_q (last_q)
  );

  coal_timer #(.TMO_W(TMO_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart    (op == OP_START),
    .active     (pending),
    .cfg_timeout(cfg_timeout),
    .expired    (tmo_expired)
  );

  coal_decide #(.NQ(NUM_QUEUES), .QW(QW), .GSH(GSH), .CNT_W(CNT_W)) u_decide (
    .pending    (pending),
    .pend_cnt   (pend_cnt),
    .pend_grp   (pend_grp),
    .last_q     (last_q),
    .tmo_expired(tmo_expired),
    .rep_valid  (rep_valid),
    .rep_queue  (rep_queue),
    .cfg_coal_en(cfg_coal_en),
    .cfg_depth  (cfg_depth),
    .rep_ready  (rep_ready),
    .op         (op),
    .flush      (flush),
    .flush_cnt  (flush_cnt),
    .flush_q    (flush_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_queue <= '0;
      irq_count <= '0;
    end else begin
      irq_valid <= flush;
      if (flush) begin
        irq_queue <= flush_q;
        irq_count <= flush_cnt;
      end
    end
  end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int NQ    = 128,
  parameter int QW    = 7,
  parameter int GSH   = 3,
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic [QW-1:0]     rep_queue,
  input logic [NQ-1:0]     cfg_coal_en,
  input logic              irq_valid,
  input logic [QW-1:0]     irq_queue,
  input logic [CNT_W-1:0]  irq_count,
  input logic              pending,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic [QW-GSH-1:0] pend_grp,
  input logic              tmo_expired
);
  a_r7_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_count != '0);

  a_r6_solo_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_ready && !cfg_coal_en[rep_queue])
      |=> (irq_valid && irq_count == CNT_W'(1) && irq_queue == $past(rep_queue)));

  a_r5_switch_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rep_valid && rep_queue[QW-1:GSH] != pend_grp) |-> !rep_ready);

  a_r5_switch_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rep_valid && rep_queue[QW-1:GSH] != pend_grp)
      |=> (irq_valid && irq_count == $past(pend_cnt)));

  a_r4_timeout_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && tmo_expired) |=> irq_valid);

  a_r8_stall_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_ready |-> pending);
endmodule

bind reply_coalescer coal_checker #(
  .NQ(NUM_QUEUES), .QW(QW), .GSH(GSH), .CNT_W(CNT_W)
) u_coal_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rep_valid  (rep_valid),
  .rep_ready  (rep_ready),
  .rep_queue  (rep_queue),
  .cfg_coal_en(cfg_coal_en),
  .irq_valid  (irq_valid),
  .irq_queue  (irq_queue),
  .irq_count  (irq_count),
  .pending    (pending),
  .pend_cnt   (pend_cnt),
  .pend_grp   (pend_grp),
  .tmo_expired(tmo_expired)
);

// File: tb/test_reply_coalescer.sv
module test_reply_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 128;
  localparam int QW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [7:0]    cfg_depth = 8'd4;
  logic [15:0]   cfg_timeout = 16'h20;
  logic [NQ-1:0] cfg_coal_en = '1;
  logic          rep_valid = 1'b0;
  logic          rep_ready;
  logic [QW-1:0] rep_queue = '0;
  logic          irq_valid;
  logic [QW-1:0] irq_queue;
  logic [7:0]    irq_count;

  reply_coalescer i_reply_coalescer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_depth(cfg_depth),
    .cfg_timeout(cfg_timeout), .cfg_coal_en(cfg_coal_en),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_queue(rep_queue),
    .irq_valid(irq_valid), .irq_queue(irq_queue), .irq_count(irq_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 1'b0;
  int tick_mode = 1;  // 1: every cycle, 0: random

  bit    m_pend = 1'b0;
  int    m_cnt = 0, m_grp = 0, m_last = 0, m_tmo = 0;
  bit    e_fl;
  int    e_cnt, e_q;
  string e_req;

  function automatic int eff_depth();
    return (cfg_depth == 0) ? 1 : int'(cfg_depth);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // inputs already driven at negedge; model one edge and compare
  task automatic step(output bit acc);
    bit tmo_hit, conf, solo, exp_ready, old_pend, started;
    int n;
    tick = (tick_mode == 1) ? 1'b1 : (($urandom % 3) == 0);
    #1;
    solo     = rep_valid && !cfg_coal_en[rep_queue];
    tmo_hit  = m_pend && (m_tmo > int'(cfg_timeout));
    conf     = m_pend && rep_valid && ((int'(rep_queue) / 8 != m_grp) || solo);
    exp_ready = !(tmo_hit || conf);
    check(rep_ready == exp_ready, conf ? "R5" : "R8", "rep_ready",
          int'(rep_ready), int'(exp_ready));
    old_pend = m_pend;
    started  = 1'b0;
    e_fl = 1'b0; e_cnt = 0; e_q = 0; e_req = "R7";
    acc = rep_valid && exp_ready;
    if (tmo_hit || conf) begin
      e_fl = 1'b1; e_cnt = m_cnt; e_q = m_last;
      e_req = tmo_hit ? "R4" : (solo ? "R6" : "R5");
      m_pend = 1'b0;
    end else if (rep_valid) begin
      if (solo) begin
        e_fl = 1'b1; e_cnt = 1; e_q = int'(rep_queue); e_req = "R6";
      end else begin
        n = m_pend ? m_cnt + 1 : 1;
        if (n >= eff_depth()) begin
          e_fl = 1'b1; e_cnt = n; e_q = int'(rep_queue); e_req = "R3";
          m_pend = 1'b0;
        end else if (m_pend) begin
          m_cnt = n; m_last = int'(rep_queue);
        end else begin
          m_pend = 1'b1; m_cnt = 1; m_grp = int'(rep_queue) / 8;
          m_last = int'(rep_queue); started = 1'b1;
        end
      end
    end
    if (started) m_tmo = 0;
    else if (old_pend && tick && m_tmo != 65535) m_tmo++;
    @(posedge clk);
    @(negedge clk);
    if (irq_valid) irq_seen++;
    check(irq_valid == e_fl, e_req, "irq_valid", int'(irq_valid), int'(e_fl));
    if (e_fl) begin
      check(int'(irq_count) == e_cnt, e_req, "irq_count", int'(irq_count), e_cnt);
      check(int'(irq_queue) == e_q, "R2", "irq_queue", int'(irq_queue), e_q);
    end
  endtask

  task automatic send(input int q);
    bit acc;
    rep_valid = 1'b1;
    rep_queue = QW'(q);
    do step(acc); while (!acc);
    rep_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    bit acc;
    repeat (n) step(acc);
  endtask

  task automatic drain();
    bit acc;
    int tm;
    tm = tick_mode;
    tick_mode = 1;
    while (m_pend) step(acc);
    tick_mode = tm;
  endtask

  task automatic scenario(input int g0, input int g1, input int g2,
                          input int g3, input int g4, input int g5,
                          input int exp_irq);
    int base;
    base = irq_seen;
    send(g0 * 8); send(g1 * 8 + 1); send(g2 * 8 + 2); send(g3 * 8 + 3);
    if (g4 >= 0) send(g4 * 8 + 4);
    if (g5 >= 0) send(g5 * 8 + 5);
    idle(40);
    check(irq_seen - base == exp_irq, "R9", "interrupt total",
          irq_seen - base, exp_irq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_valid == 1'b0, "R1", "irq_valid in reset", int'(irq_valid), 0);
    check(rep_ready == 1'b1, "R1", "rep_ready in reset", int'(rep_ready), 1);
    rst_n = 1'b1;
    void'($urandom(32'd2024));

    // R9 reference sequences, depth 4 timeout 0x20
    cfg_depth = 8'd4; cfg_timeout = 16'h20;
    scenario(4, 4, 6, 6, -1, -1, 2);
    scenario(4, 5, 6, 7, -1, -1, 4);
    scenario(4, 4, 4, 4, 4, 5, 3);

    // R3 depth 0 and depth 1 flush every reply
    cfg_depth = 8'd0; send(10); send(11);
    cfg_depth = 8'd1; send(12); idle(2);

    // R4 timeout with exact age, R2 accumulation inside a group
    cfg_depth = 8'd20; cfg_timeout = 16'd5;
    send(16); send(17); send(23); idle(12);
    tick_mode = 0; send(40); idle(20); drain(); tick_mode = 1;

    // R6 solo queue forces prior set out
    cfg_depth = 8'd4; cfg_timeout = 16'd8;
    cfg_coal_en[13] = 1'b0;
    send(8); send(9); send(13); send(13); idle(14);

    // R5/R8 random traffic
    for (int round = 0; round < 8; round++) begin
      drain();
      cfg_depth   = 8'($urandom % 7);
      cfg_timeout = 16'($urandom % 11);
      for (int q = 0; q < NQ; q++) cfg_coal_en[q] = (($urandom % 8) != 0);
      tick_mode = round % 2;
      for (int k = 0; k < 300; k++) begin
        if (($urandom % 4) != 0) send(((3 + ($urandom % 3)) * 8) + ($urandom % 8));
        else idle(1);
      end
    end
    drain();
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule